// File: doc/BRIEF.md
# Triggered Waveform Capture with Double-Buffered Readout

This block is the per-channel front end of a digitizer. Every clock cycle a 14-bit sample goes into a circular pipeline memory, so a recent history of the input is always held. When a trigger arrives, the block copies a 32-sample window into the event buffer that is currently filling. The window starts a programmable number of samples before the trigger. The stored event has a time-stamp word first, then the samples. The time stamp comes from a free-running counter.

There are two event banks. One fills while the bus side drains the other. A readout pulse swaps their roles. If a capture is in progress when the pulse arrives, the swap waits until that capture has finished, so an event never spans both banks. Each bank reports how many events it holds. When the filling bank is full, further triggers are dropped and a sticky overflow flag is set.

Everything runs on one clock. The readout pulse and the read port are assumed to be synchronous to the sample clock.

Top module: `wavecap_top`

## Requirements
- R1: While reset is held, the outputs are as follows: `rd_count` = 0, `fill_count` = 0, `overflow` = 0 and `cap_busy` = 0.
- R2: Event n in a bank occupies the 33 words at n*33 up to n*33+32.
  - Word 0 is the time stamp. It equals the number of clock edges with reset released that came before the trigger edge.
  - Word k+1 (k = 0..31) holds, in bits 13:0 with zero upper bits, the input sampled at the edge `cfg_lookback` cycles before the trigger edge plus k.
- R3: `cfg_lookback` may take any value from 0 to PIPE_DEPTH-2. Both end values capture the correct window.
- R4: An accepted trigger raises `cap_busy` from the next cycle for exactly 33 cycles. A trigger seen while `cap_busy` is high is ignored and stores nothing.
- R5: A trigger that finds the filling bank at MAX_EVT events is dropped. It leaves `fill_count` unchanged and sets `overflow`, which stays set until reset.
- R6: A readout pulse seen while idle swaps the banks at that edge. The former filling bank becomes readable, with `rd_count` equal to its event count, and the new filling bank starts at 0 events.
- R7: A readout pulse seen during a capture is deferred. `rd_count` is unchanged until the first idle edge, and the swap happens at that edge.
- R8: A trigger and a swap taking effect at the same edge put the new event into the bank that is filling after the swap.
- R9: `rd_data` returns the readable bank's word at `rd_addr` one clock after the address is applied.
- R10: `fill_count` reports the number of accepted events in the filling bank. It counts an event from the edge the event's trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | SAMPLE_W | ADC sample, one per cycle |
| trig_in | input | 1 | Trigger request, one cycle |
| swap_in | input | 1 | Readout pulse requesting a bank swap |
| cfg_lookback | input | log2(PIPE_DEPTH) | Samples before the trigger where the window starts |
| rd_addr | input | log2(MAX_EVT*(WIN+1)) | Word address in the readable bank |
| rd_data | output | 32 | Registered read data |
| rd_count | output | log2(MAX_EVT+1) | Events held in the readable bank |
| fill_count | output | log2(MAX_EVT+1) | Events held in the filling bank |
| cap_busy | output | 1 | Capture in progress |
| overflow | output | 1 | Sticky flag for a trigger dropped because the bank was full |

## Verification
- **Busy timing:** `cap_busy` and `fill_count` change at the edge that accepts the trigger. `cap_busy` falls 33 edges later. The data for that event is complete in the bank at that same edge.
- **Swap timing:** an idle swap changes `rd_count` and `fill_count` at the pulse edge. A deferred swap changes them at the 34th edge after the trigger.
- **Read latency:** a read returns data one edge after its address.
- **How the bench keeps to this:** it drives every input on the falling edge and samples every output on the next falling edge. A cycle-level reference model, updated on rising edges from the requirements, tracks busy time, bank roles, counts and the expected words. The model fills the expected-word queues; the drain task pops them against `rd_data`.

// File: rtl/wavecap_pkg.sv
// Shared definitions for the waveform-capture block.
// Assumes a single clock domain for all users of these types.
package wavecap_pkg;
    localparam int WORD_W = 32;   // event buffer word, also time-stamp width

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_RUN  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/wavecap_pipe.sv
// Circular sample history. One sample is written per cycle after reset is
// released, at address = (edges since reset) mod DEPTH. The read port is
// registered (one cycle). Assumes DEPTH is a power of two so the pointer wraps
// naturally. A read sees writes from earlier edges.
module wavecap_pipe #(
    parameter int SAMPLE_W = 14,
    parameter int DEPTH    = 1024,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] din,
    input  logic [AW-1:0]       rd_addr,
    output logic [AW-1:0]       wr_ptr,
    output logic [SAMPLE_W-1:0] rd_data
);
    logic [SAMPLE_W-1:0] mem [DEPTH];

    // Advance the write pointer each cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_ptr <= '0;
        else        wr_ptr <= wr_ptr + 1'b1;
    end

    // Store the incoming sample and perform the registered read.
    always_ff @(posedge clk) begin
        if (rst_n) mem[wr_ptr] <= din;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/wavecap_capture.sv
// Capture sequencer. On start it latches the time stamp, the pipeline read
// base (write pointer minus look-back) and the bank word base of the event.
// It then writes WIN+1 words on consecutive cycles: the stamp, then the
// samples. Each sample is read from the pipeline one cycle ahead of its write.
// Assumes start is only raised while idle and lookback <= DEPTH-2.
module wavecap_capture
    import wavecap_pkg::*;
#(
    parameter int SAMPLE_W  = 14,
    parameter int WIN       = 32,
    parameter int PIPE_AW   = 10,
    parameter int BUF_AW    = 11,
    parameter int EVT_IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WORD_W-1:0]    ts_in,
    input  logic [PIPE_AW-1:0]   wr_ptr,
    input  logic [PIPE_AW-1:0]   lookback,
    input  logic [EVT_IDX_W-1:0] evt_idx,
    input  logic [SAMPLE_W-1:0]  pipe_data,
    output logic [PIPE_AW-1:0]   pipe_addr,
    output logic                 busy,
    output logic                 buf_we,
    output logic [BUF_AW-1:0]    buf_waddr,
    output logic [WORD_W-1:0]    buf_wdata
);
    localparam int EVT_WORDS = WIN + 1;
    localparam int IW        = $clog2(EVT_WORDS + 1);
    localparam logic [IW-1:0] LAST = IW'(WIN);

    cap_state_e          state;
    logic [IW-1:0]       widx;
    logic [PIPE_AW-1:0]  rbase;
    logic [BUF_AW-1:0]   wbase;
    logic [WORD_W-1:0]   ts_q;

    // Sequence the word index through one event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
            widx  <= '0;
        end else begin
            case (state)
                CAP_IDLE: if (start) begin
                    state <= CAP_RUN;
                    widx  <= '0;
                end
                CAP_RUN: begin
                    if (widx == LAST) state <= CAP_IDLE;
                    else              widx  <= widx + 1'b1;
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    // Latch the per-event context at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q  <= '0;
            rbase <= '0;
            wbase <= '0;
        end else if (start && state == CAP_IDLE) begin
            ts_q  <= ts_in;
            rbase <= wr_ptr - lookback;
            wbase <= BUF_AW'(evt_idx) * BUF_AW'(EVT_WORDS);
        end
    end

    // Drive the pipeline read and the bank write for the current word.
    always_comb begin
        busy      = (state == CAP_RUN);
        buf_we    = busy;
        buf_waddr = wbase + BUF_AW'(widx);
        pipe_addr = rbase + PIPE_AW'(widx);
        buf_wdata = (widx == '0) ? ts_q : WORD_W'(pipe_data);
    end

    // R4/R2: an accepted start leads to a busy cycle writing the latched stamp.
    a_r4_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && buf_we && buf_wdata == $past(ts_in)))
        else $error("a_r4_start_runs");
endmodule

// File: rtl/wavecap_evbuf.sv
// Two event banks with one write port and one registered read port.
// Writes go to bank wsel; reads come from bank rsel one cycle later.
// Assumes waddr < BANK_WORDS whenever we is high.
module wavecap_evbuf
    import wavecap_pkg::*;
#(
    parameter int BANK_WORDS = 1056,
    localparam int AW        = $clog2(BANK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wsel,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rsel,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic rsel_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WORD_W-1:0] mem [BANK_WORDS];
        logic [WORD_W-1:0] bank_q;
        // Write when this bank is selected; always read at raddr.
        always_ff @(posedge clk) begin
            if (we && wsel == 1'(b)) mem[waddr] <= wdata;
            bank_q <= mem[raddr];
        end
    end

    // Remember which bank the registered read belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) rsel_q <= 1'b0;
        else        rsel_q <= rsel;
    end

    assign rdata = rsel_q ? g_bank[1].bank_q : g_bank[0].bank_q;

    // R2: writes stay inside a bank.
    a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < BANK_WORDS))
        else $error("a_r2_addr_range");
endmodule

// File: rtl/wavecap_top.sv
// Triggered waveform capture with two alternating event banks.
// Holds the time-stamp counter, bank roles, event counts, the deferred-swap
// request and the sticky overflow flag. Assumes trig_in, swap_in and the read
// port are synchronous to clk, and cfg_lookback <= PIPE_DEPTH-2.
module wavecap_top
    import wavecap_pkg::*;
#(
    parameter int SAMPLE_W   = 14,
    parameter int WIN        = 32,
    parameter int PIPE_DEPTH = 1024,
    parameter int MAX_EVT    = 32,
    localparam int PIPE_AW    = $clog2(PIPE_DEPTH),
    localparam int EVT_WORDS  = WIN + 1,
    localparam int BANK_WORDS = MAX_EVT * EVT_WORDS,
    localparam int BUF_AW     = $clog2(BANK_WORDS),
    localparam int CNT_W      = $clog2(MAX_EVT + 1),
    localparam int EVT_IDX_W  = $clog2(MAX_EVT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                trig_in,
    input  logic                swap_in,
    input  logic [PIPE_AW-1:0]  cfg_lookback,
    input  logic [BUF_AW-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic [CNT_W-1:0]    rd_count,
    output logic [CNT_W-1:0]    fill_count,
    output logic                cap_busy,
    output logic                overflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_EVT);

    logic [WORD_W-1:0]    ts_q;
    logic                 fill_sel, pend_q, ovf_q;
    logic [CNT_W-1:0]     cnt0_q, cnt1_q, fill_cnt, read_cnt;
    logic                 busy, swap_now, fill_full, accept;
    logic [EVT_IDX_W-1:0] evt_idx;
    logic [PIPE_AW-1:0]   wr_ptr, pipe_addr;
    logic [SAMPLE_W-1:0]  pipe_data;
    logic                 buf_we;
    logic [BUF_AW-1:0]    buf_waddr;
    logic [WORD_W-1:0]    buf_wdata;

    // Decide swap and trigger acceptance for this edge.
    always_comb begin
        fill_cnt  = fill_sel ? cnt1_q : cnt0_q;
        read_cnt  = fill_sel ? cnt0_q : cnt1_q;
        swap_now  = (swap_in | pend_q) & ~busy;
        fill_full = ~swap_now & (fill_cnt == CNT_MAX);
        accept    = trig_in & ~busy & ~fill_full;
        evt_idx   = swap_now ? '0 : fill_cnt[EVT_IDX_W-1:0];
    end

    // Free-running time-stamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + 1'b1;
    end

    // Bank roles and per-bank event counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sel <= 1'b0;
            cnt0_q   <= '0;
            cnt1_q   <= '0;
        end else if (swap_now) begin
            fill_sel <= ~fill_sel;
            if (fill_sel) cnt0_q <= accept ? CNT_W'(1) : '0;
            else          cnt1_q <= accept ? CNT_W'(1) : '0;
        end else if (accept) begin
            if (fill_sel) cnt1_q <= cnt1_q + 1'b1;
            else          cnt0_q <= cnt0_q + 1'b1;
        end
    end

    // Hold a readout pulse that arrived during a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (swap_now) pend_q <= 1'b0;
        else if (swap_in)  pend_q <= 1'b1;
    end

    // Sticky flag for triggers dropped on a full bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ovf_q <= 1'b0;
        else if (trig_in && !busy && fill_full) ovf_q <= 1'b1;
    end

    wavecap_pipe #(.SAMPLE_W(SAMPLE_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .din(sample_in), .rd_addr(pipe_addr),
        .wr_ptr(wr_ptr), .rd_data(pipe_data)
    );

    wavecap_capture #(
        .SAMPLE_W(SAMPLE_W), .WIN(WIN), .PIPE_AW(PIPE_AW),
        .BUF_AW(BUF_AW), .EVT_IDX_W(EVT_IDX_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .start(accept), .ts_in(ts_q),
        .wr_ptr(wr_ptr), .lookback(cfg_lookback), .evt_idx(evt_idx),
        .pipe_data(pipe_data), .pipe_addr(pipe_addr), .busy(busy),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
    );

    wavecap_evbuf #(.BANK_WORDS(BANK_WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .wsel(fill_sel),
        .waddr(buf_waddr), .wdata(buf_wdata), .rsel(~fill_sel),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assign rd_count   = read_cnt;
    assign fill_count = fill_cnt;
    assign cap_busy   = busy;
    assign overflow   = ovf_q;

    // R5: overflow never clears outside reset.
    a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow) else $error("a_r5_overflow_sticky");

    // R5: a bank never counts past its capacity.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count <= CNT_MAX) && (rd_count <= CNT_MAX))
        else $error("a_r5_count_bound");

    // R6: an idle readout pulse exposes the filled bank and restarts filling.
    a_r6_swap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_in && !cap_busy) |=> (fill_count <= CNT_W'(1) && rd_count == $past(fill_count)))
        else $error("a_r6_swap_clears");

    // R7: the readable bank does not change while a capture runs.
    a_r7_hold_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_busy && $past(cap_busy)) |-> $stable(rd_count))
        else $error("a_r7_hold_bank");
endmodule

// File: tb/wavecap_top_tb_top.sv
module wavecap_top_tb_top;
    localparam int DEPTH = 1024;
    localparam int WIN   = 32;
    localparam int MAXE  = 32;
    localparam int EW    = WIN + 1;
    localparam int AW    = 10;
    localparam int BAW   = 11;
    localparam int CW    = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, trig_in, swap_in;
    logic [13:0]   sample_in;
    logic [AW-1:0] cfg_lookback;
    logic [BAW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic [CW-1:0] rd_count, fill_count;
    logic          cap_busy, overflow;

    wavecap_top dut_i (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .trig_in(trig_in),
        .swap_in(swap_in), .cfg_lookback(cfg_lookback), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_count(rd_count), .fill_count(fill_count),
        .cap_busy(cap_busy), .overflow(overflow)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Sample stimulus, changed away from the active edge.
    int scnt = 0;
    always @(negedge clk) begin
        scnt++;
        sample_in <= 14'(scnt * 37 + 11);
    end

    // Reference model built from the requirements.
    logic [13:0] hist [int];
    logic [31:0] q0[$], q1[$];
    int  cyc, left, ev_t, ev_l;
    int  mcnt [2];
    bit  mfill, mpend, movf, ev_bank, mbusy, swapn;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; left = 0; mfill = 0; mpend = 0; movf = 0;
            mcnt[0] = 0; mcnt[1] = 0;
            q0.delete(); q1.delete();
        end else begin
            hist[cyc] = sample_in;
            mbusy = (left > 0);
            if (left > 0) begin
                left--;
                if (left == 0) begin
                    if (ev_bank) q1.push_back(32'(ev_t)); else q0.push_back(32'(ev_t));
                    for (int k = 0; k < WIN; k++) begin
                        if (ev_bank) q1.push_back({18'd0, hist[ev_t - ev_l + k]});
                        else         q0.push_back({18'd0, hist[ev_t - ev_l + k]});
                    end
                end
            end
            swapn = (swap_in || mpend) && !mbusy;
            if (swapn) begin
                mfill = !mfill;
                if (mfill) q1.delete(); else q0.delete();
                mcnt[mfill] = 0;
                mpend = 0;
            end else if (swap_in) mpend = 1;
            if (trig_in && !mbusy) begin
                if (mcnt[mfill] == MAXE) movf = 1;
                else begin
                    mcnt[mfill]++;
                    left = EW; ev_t = cyc; ev_l = int'(cfg_lookback); ev_bank = mfill;
                end
            end
            cyc++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one-cycle trigger and/or readout pulse with a look-back setting.
    task automatic pulse(input bit t, input bit s, input int lb);
        cfg_lookback = AW'(lb);
        trig_in = t; swap_in = s;
        @(negedge clk);
        trig_in = 0; swap_in = 0;
    endtask

    // Compare status ports with the model (R4, R5, R6, R10).
    task automatic chk_status();
        chk(fill_count == CW'(mcnt[mfill]), "R10 fill_count", fill_count, mcnt[mfill]);
        chk(rd_count == CW'(mcnt[!mfill]), "R6 rd_count", rd_count, mcnt[!mfill]);
        chk(overflow == movf, "R5 overflow", overflow, movf);
        chk(cap_busy == (left > 0), "R4 cap_busy", cap_busy, left > 0);
    endtask

    // Monitor: read the whole readable bank and pop expected words (R2, R9).
    task automatic drain(input string req);
        int n;
        bit rb;
        logic [31:0] exp;
        n = int'(rd_count);
        rb = !mfill;
        chk((rb ? q1.size() : q0.size()) == n * EW, req, rb ? q1.size() : q0.size(), n * EW);
        for (int w = 0; w < n * EW; w++) begin
            rd_addr = BAW'(w);
            @(negedge clk);
            exp = rb ? q1.pop_front() : q0.pop_front();
            chk(rd_data == exp, req, rd_data, exp);
        end
    endtask

    initial begin
        rst_n = 0; trig_in = 0; swap_in = 0; cfg_lookback = '0; rd_addr = '0;
        idle(4);
        // R1: reset values
        chk(rd_count == 0, "R1 rd_count", rd_count, 0);
        chk(fill_count == 0, "R1 fill_count", fill_count, 0);
        chk(overflow == 0, "R1 overflow", overflow, 0);
        chk(cap_busy == 0, "R1 cap_busy", cap_busy, 0);
        rst_n = 1;
        idle(1100);

        // R2/R4: capture with look-back 10, second trigger inside capture ignored
        pulse(1, 0, 10);
        chk(cap_busy == 1, "R4 busy after trigger", cap_busy, 1);
        chk(fill_count == 1, "R10 count at accept", fill_count, 1);
        idle(4);
        pulse(1, 0, 10);
        idle(40);
        chk(fill_count == 1, "R4 ignored trigger", fill_count, 1);
        chk_status();
        pulse(0, 1, 0);
        chk(rd_count == 1, "R6 swap exposes event", rd_count, 1);
        chk_status();
        drain("R2 R9 lookback 10");

        // R3 lower end plus R7 deferred swap
        pulse(1, 0, 0);
        idle(3);
        pulse(0, 1, 0);
        idle(2);
        chk(rd_count == 1, "R7 swap deferred", rd_count, 1);
        chk_status();
        idle(40);
        chk(rd_count == 1 && fill_count == 0, "R7 swap after capture", rd_count, 1);
        chk_status();
        drain("R3 R2 lookback 0");

        // R3 upper end: look-back DEPTH-2
        pulse(1, 0, DEPTH - 2);
        idle(40);
        pulse(0, 1, 0);
        chk_status();
        drain("R3 lookback max");

        // R8: trigger and swap at the same edge
        pulse(1, 1, 5);
        idle(40);
        chk(fill_count == 1, "R8 event in new bank", fill_count, 1);
        chk(rd_count == 0, "R8 readable bank empty", rd_count, 0);
        chk_status();
        pulse(0, 1, 0);
        drain("R8 R2 same-edge");

        // R5: fill the bank, then one more trigger
        for (int i = 0; i < MAXE; i++) begin
            pulse(1, 0, 3 + i);
            idle(36);
        end
        chk(fill_count == CW'(MAXE) && overflow == 0, "R5 full no overflow", fill_count, MAXE);
        pulse(1, 0, 3);
        chk(overflow == 1, "R5 overflow set", overflow, 1);
        chk(cap_busy == 0, "R5 dropped trigger no capture", cap_busy, 0);
        idle(36);
        chk(fill_count == CW'(MAXE), "R5 count unchanged", fill_count, MAXE);
        chk_status();
        pulse(0, 1, 0);
        chk_status();
        drain("R5 R2 full bank");
        chk(overflow == 1, "R5 overflow sticky", overflow, 1);
        summary();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 10);
        chk(0, "watchdog", 0, 1);
        summary();
    end
endmodule